// File: doc/BRIEF.md
# Programmable Asynchronous Serial Character Transmitter

This block sends one character at a time on a serial output line. The host places a byte in a one-deep holding register. When the serializer is idle, the held byte moves into a shift register and the holding register is marked empty again, so the host can queue the next byte while the current one is on the line. Each character goes out as a low start bit, then 5 to 8 data bits with the least significant bit first. An optional even or odd parity bit follows, and the character ends with a high stop period of one, one and a half or two bit times.

Bit timing comes from an enable pulse at sixteen times the bit rate. This pulse is made outside the block. A bit lasts sixteen enable pulses, and a stop period of one and a half bits lasts 24 pulses. An active-low clear-to-send input must be low before a new character can start. A character that has already started always finishes, whatever that input does. The format inputs are sampled when a character starts, so changing them mid-character affects only later characters.

Top module: `serial_char_tx`

## Requirements
- R1: During and after synchronous reset (rst_n low), txd is 1 and hold_empty is 1.
- R2: A character is a 0 start bit, the data bits with bit 0 first and the higher bits in ascending order, an optional parity bit, and a stop period at 1. Between characters the line stays at 1.
- R3: word_len selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: Bits of wr_data at or above the selected word length are ignored. They are not sent and they do not affect the parity bit.
- R5: parity_mode 01 adds an even parity bit (data ones plus parity bit is an even count). 10 adds an odd parity bit. 00 and 11 send no parity bit.
- R6: Every start, data and parity bit lasts 16 tick16 pulses. stop_mode 00 gives a 16-pulse stop, 01 gives 24 and 10 or 11 gives 32. A queued character starts within one clock after the previous stop ends.
- R7: hold_empty goes to 0 in the clock after a write (wr_en high), and goes to 1 in the clock after the held byte moves into the shift register.
- R8: A character starts only while cts_n is 0. While cts_n is 1, the line stays idle and the held byte stays queued.
- R9: Changes to word_len, parity_mode, stop_mode or cts_n after a character has started do not alter that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW | Byte to send |
| word_len | input | 2 | Data bit count select (5 to 8) |
| parity_mode | input | 2 | Parity select: none, even, odd |
| stop_mode | input | 2 | Stop length select: 1, 1.5, 2 bits |
| cts_n | input | 1 | Active-low clear-to-send gate |
| txd | output | 1 | Serial data line |
| hold_empty | output | 1 | Holding register can take a new byte |

## Verification
The bench sends a 5-bit character whose unused high bits would flip the even parity bit. A design that kept those bits would send a wrong parity bit or extra data bits. It times the gap between back-to-back characters for each stop setting. This catches a 1.5-bit stop that is rounded to 1 or 2 bits, and a wrong tick count per bit. It holds clear-to-send off with a byte queued, and it changes the format and the gate in the middle of a character. A design without the gate would start early, and one that did not latch the format would cut or stretch the character in flight.

// File: rtl/sctx_pkg.sv
// Package: shared types and code points for the serial character transmitter.
// Assumes: the 2-bit format fields are decoded only by the frame sequencer.
package sctx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_t;

    typedef struct packed {
        logic [1:0] wlen;   // 00..11 -> 5..8 data bits
        logic [1:0] pmode;  // 01 even, 10 odd, else none
        logic [1:0] stop;   // 00 one, 01 one and a half, else two
    } tx_fmt_t;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;
    localparam logic [1:0] STOP_ONE = 2'b00;
    localparam logic [1:0] STOP_ONEHALF = 2'b01;

endpackage

// File: rtl/sctx_hold.sv
// Module: one-deep holding register with an empty flag.
// Assumes: take is raised only while the register is full. A write in the
// same cycle as take refills the register, so it stays full.
module sctx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic [DW-1:0] hold_q,
    output logic          empty
);

    // Capture host bytes and track whether one is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            empty  <= 1'b1;
        end else if (wr_en) begin
            hold_q <= wr_data;
            empty  <= 1'b0;
        end else if (take) begin
            empty  <= 1'b1;
        end
    end

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !empty);  // R7
    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> empty);  // R7

endmodule

// File: rtl/sctx_frame.sv
// Module: frame sequencer. It loads a byte, then sends the start bit, the
// data bits LSB first, the optional parity bit and the stop period.
// Assumes: tick is a one-cycle enable at OVS times the bit rate. The format
// is latched on start and held to the end of the character.
module sctx_frame
    import sctx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  tx_fmt_t       fmt,
    output logic          idle,
    output logic          txd
);

    localparam int CW = $clog2(2 * OVS);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(OVS - 1);
    localparam logic [CW-1:0] LAST_S15 = CW'(OVS + OVS / 2 - 1);
    localparam logic [CW-1:0] LAST_S2  = CW'(2 * OVS - 1);
    localparam logic [IW-1:0] IDX_BASE = IW'(DW - 4);

    tx_state_t     state;
    tx_fmt_t       fmt_q;
    logic [DW-1:0] shreg;
    logic          par_bit;
    logic [CW-1:0] tick_cnt;
    logic [IW-1:0] bit_idx;
    logic [CW-1:0] tick_last;
    logic [IW-1:0] last_idx;
    logic          par_en;
    logic [DW-1:0] masked;

    // Clear data bits at or above the selected word length.
    function automatic logic [DW-1:0] mask_word(input logic [DW-1:0] d,
                                                input logic [1:0] wl);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) begin
            m[i] = (i < DW - 3 + int'(wl)) ? d[i] : 1'b0;
        end
        return m;
    endfunction

    // Decode the latched format into limits for the current character.
    always_comb begin
        masked   = mask_word(data, fmt.wlen);
        last_idx = IDX_BASE + IW'(fmt_q.wlen);
        par_en   = (fmt_q.pmode == PAR_EVEN) || (fmt_q.pmode == PAR_ODD);
        if (state == ST_STOP) begin
            case (fmt_q.stop)
                STOP_ONE:     tick_last = LAST_BIT;
                STOP_ONEHALF: tick_last = LAST_S15;
                default:      tick_last = LAST_S2;
            endcase
        end else begin
            tick_last = LAST_BIT;
        end
    end

    // Step through the character one bit period at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            fmt_q    <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            tick_cnt <= '0;
            bit_idx  <= '0;
        end else if (start && state == ST_IDLE) begin
            state    <= ST_START;
            fmt_q    <= fmt;
            shreg    <= masked;
            par_bit  <= (fmt.pmode == PAR_ODD) ? ~^masked : ^masked;
            tick_cnt <= '0;
            bit_idx  <= '0;
        end else if (tick && state != ST_IDLE) begin
            if (tick_cnt != tick_last) begin
                tick_cnt <= tick_cnt + 1'b1;
            end else begin
                tick_cnt <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (bit_idx == last_idx) begin
                            state <= par_en ? ST_PAR : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    ST_PAR:  state <= ST_STOP;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Drive the line level for the bit being sent.
    always_comb begin
        idle = (state == ST_IDLE);
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= tick_last);  // R6
    AST_IDX_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (bit_idx <= last_idx));  // R3
    AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(fmt_q));  // R9

endmodule

// File: rtl/serial_char_tx.sv
// Module: top of the serial character transmitter. It connects the holding
// register to the frame sequencer and gates the handoff with clear-to-send.
// Assumes: tick16 comes from an external rate generator; cts_n is already
// synchronous to clk.
module serial_char_tx
    import sctx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    word_len,
    input  logic [1:0]    parity_mode,
    input  logic [1:0]    stop_mode,
    input  logic          cts_n,
    output logic          txd,
    output logic          hold_empty
);

    logic [DW-1:0] hold_q;
    logic          frame_idle;
    logic          handoff;
    tx_fmt_t       fmt_in;

    // Pack the format fields and decide when a character may begin.
    always_comb begin
        fmt_in  = '{wlen: word_len, pmode: parity_mode, stop: stop_mode};
        handoff = frame_idle && !hold_empty && !cts_n;
    end

    sctx_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (handoff),
        .hold_q  (hold_q),
        .empty   (hold_empty)
    );

    sctx_frame #(.DW(DW), .OVS(OVS)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick16),
        .start (handoff),
        .data  (hold_q),
        .fmt   (fmt_in),
        .idle  (frame_idle),
        .txd   (txd)
    );

    AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_idle && $past(frame_idle)) |-> !$past(cts_n));  // R8
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_idle && $past(frame_idle)) |-> txd);  // R2

endmodule

// File: tb/sim_serial_char_tx.sv
// Bench: directed scenarios for the serial character transmitter. Each task
// checks its own results. tick16 is pulsed every fourth clock.
module sim_serial_char_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] word_len = 2'b11;
    logic [1:0] parity_mode = 2'b00;
    logic [1:0] stop_mode = 2'b00;
    logic       cts_n = 1'b0;
    logic       txd;
    logic       hold_empty;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;  // 50 MHz

    serial_char_tx u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick16      (tick16),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .word_len    (word_len),
        .parity_mode (parity_mode),
        .stop_mode   (stop_mode),
        .cts_n       (cts_n),
        .txd         (txd),
        .hold_empty  (hold_empty)
    );

    // 16x enable: one clock high out of every four.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_fall(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (txd == 1'b0) seen = 1'b1;
        end
    endtask

    // Receive one character at bit centres and compare it with the
    // expected format. With mess set, the inputs are disturbed once the
    // character has started.
    task automatic rx_check(input logic [7:0] b, input logic [1:0] wl,
                            input logic [1:0] pm, input bit mess,
                            input string tag);
        int n;
        logic [7:0] exp_d;
        logic [7:0] got;
        bit pen;
        logic exp_p;
        bit seen;
        n = 5 + int'(wl);
        exp_d = b & 8'((9'd1 << n) - 9'd1);
        pen = (pm == 2'b01) || (pm == 2'b10);
        exp_p = (pm == 2'b10) ? ~^exp_d : ^exp_d;
        got = 8'h00;
        wait_fall(seen);
        chk(seen, tag, "start edge seen", int'(seen), 1);
        if (mess) begin
            word_len = ~word_len;
            parity_mode = 2'b10;
            stop_mode = 2'b10;
            cts_n = 1'b1;
        end
        repeat (32) @(negedge clk);
        chk(txd == 1'b0, tag, "start bit", int'(txd), 0);
        for (int k = 0; k < n; k++) begin
            repeat (64) @(negedge clk);
            got[k] = txd;
        end
        chk(got == exp_d, tag, "data bits", int'(got), int'(exp_d));
        if (pen) begin
            repeat (64) @(negedge clk);
            chk(txd == exp_p, tag, "parity bit", int'(txd), int'(exp_p));
        end
        repeat (64) @(negedge clk);
        chk(txd == 1'b1, tag, "stop level", int'(txd), 1);
        repeat (200) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
        chk(hold_empty == 1'b1, "R1", "empty in reset", int'(hold_empty), 1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(hold_empty == 1'b1, "R1", "empty after reset", int'(hold_empty), 1);
    endtask

    task automatic t_frame(input logic [7:0] b, input logic [1:0] wl,
                           input logic [1:0] pm, input string tag);
        word_len = wl;
        parity_mode = pm;
        stop_mode = 2'b00;
        write_byte(b);
        rx_check(b, wl, pm, 1'b0, tag);
    endtask

    // R6: gap between starts of two queued 8-bit, no-parity characters.
    task automatic t_stop(input logic [1:0] s, input int s_ticks);
        time t1;
        time t2;
        int clocks;
        int tt;
        bit seen;
        word_len = 2'b11;
        parity_mode = 2'b00;
        stop_mode = s;
        write_byte(8'hFF);
        wait_fall(seen);
        t1 = $time;
        write_byte(8'hFF);
        while (txd == 1'b0) @(negedge clk);
        wait_fall(seen);
        t2 = $time;
        clocks = int'((t2 - t1) / 20);
        tt = 16 * 9 + s_ticks;
        chk(seen && clocks >= 4 * tt - 3 && clocks <= 4 * tt + 2, "R6",
            "start-to-start clocks", clocks, 4 * tt);
        repeat (900) @(negedge clk);
    endtask

    task automatic t_empty_flag;
        word_len = 2'b11;
        parity_mode = 2'b00;
        stop_mode = 2'b00;
        cts_n = 1'b1;
        write_byte(8'h3C);
        chk(hold_empty == 1'b0, "R7", "empty after write", int'(hold_empty), 0);
        repeat (20) @(negedge clk);
        chk(txd == 1'b1, "R8", "line idle while gated", int'(txd), 1);
        cts_n = 1'b0;
        @(negedge clk);
        chk(hold_empty == 1'b1, "R7", "empty after handoff", int'(hold_empty), 1);
        chk(txd == 1'b0, "R8", "start once cts low", int'(txd), 0);
        repeat (900) @(negedge clk);
    endtask

    task automatic t_cts_hold;
        int bad;
        bad = 0;
        word_len = 2'b11;
        parity_mode = 2'b01;
        cts_n = 1'b1;
        write_byte(8'h81);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (txd != 1'b1) bad++;
        end
        chk(bad == 0, "R8", "low samples while gated", bad, 0);
        chk(hold_empty == 1'b0, "R8", "byte kept queued", int'(hold_empty), 0);
        cts_n = 1'b0;
        rx_check(8'h81, 2'b11, 2'b01, 1'b0, "R8");
    endtask

    task automatic t_midframe;
        word_len = 2'b11;
        parity_mode = 2'b00;
        stop_mode = 2'b00;
        write_byte(8'h6A);
        rx_check(8'h6A, 2'b11, 2'b00, 1'b1, "R9");
        cts_n = 1'b0;
        word_len = 2'b11;
        parity_mode = 2'b00;
        stop_mode = 2'b00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        t_frame(8'hA5, 2'b11, 2'b00, "R2");
        t_frame(8'hE3, 2'b00, 2'b01, "R4");
        t_frame(8'h2C, 2'b01, 2'b10, "R5");
        t_frame(8'h55, 2'b10, 2'b01, "R3");
        t_frame(8'hC6, 2'b10, 2'b11, "R5");
        t_stop(2'b00, 16);
        t_stop(2'b01, 24);
        t_stop(2'b10, 32);
        t_stop(2'b11, 32);
        t_empty_flag();
        t_cts_hold();
        t_midframe();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule